// File: doc/BRIEF.md
# Translated Basic-Block Lookup Cache

This block sits next to the fetch stage of a processor that is paired with a reconfigurable execution array. Each fetch cycle it checks whether the program counter is the first address of a basic block for which a configuration already exists. The check runs against a small, fully associative table of block start addresses. Each valid entry carries a configuration slot number. On a match the block freezes the processor pipeline and starts the array on that slot. It then waits for the array to report completion. When the stall ends it returns the address at which ordinary fetch continues.

The translation unit adds entries whenever it opens a new configuration. An entry whose address is already present is overwritten in place. A new address goes into the lowest free row while the table still has room. Once the table is full, rows are reused in rotating order. A small local store keeps the fall-through address of every configuration slot.

Top module: `bb_lookup_cache`

## Requirements
- R1: After reset every table row is invalid, `stall`, `cfg_start` and `resume_valid` are low, and a lookup of any address misses.
- R2: When idle, a lookup (`fetch_valid` high) whose address matches a valid row, with no same-address write in that cycle, raises `stall` and a one-cycle `cfg_start` in the next cycle. In that same cycle `cfg_index` carries the slot number stored in the row.
- R3: A lookup whose address matches no valid row leaves `stall` and `cfg_start` low.
- R4: While `stall` is high, fetch is suspended: further lookups, even matching ones, start nothing.
- R5: `array_done` sampled high during a stall keeps `stall` high for one more cycle. `stall` then drops, and in that same cycle `resume_valid` pulses for one cycle with `resume_pc` equal to the fall-through address of the running slot.
- R6: Writing a new address while some rows are free fills the lowest-numbered free row.
- R7: Writing an address that is already present replaces that row's slot number. It creates no second row and does not move the rotation pointer.
- R8: Writing a new address into a full table replaces rows in rotating order. The first replacement evicts row 0, the next evicts row 1, and so on, with wrap.
- R9: A lookup and a write of the same address in the same cycle make the lookup miss. A lookup of that address in a later cycle hits.
- R10: Every write also stores its fall-through address against its slot number, and the latest write to a slot wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch stage presents an address this cycle |
| fetch_pc | input | 32 | Current fetch address |
| alloc_valid | input | 1 | Translation unit writes an entry |
| alloc_pc | input | 32 | Block start address to record |
| alloc_cfg | input | 4 | Configuration slot for the block |
| alloc_fallthru | input | 32 | Address where fetch resumes after the block |
| array_done | input | 1 | Array has finished the running block |
| stall | output | 1 | Processor pipeline frozen |
| cfg_start | output | 1 | One-cycle start pulse to the array |
| cfg_index | output | 4 | Configuration slot to run |
| resume_valid | output | 1 | One-cycle pulse: fetch restarts |
| resume_pc | output | 32 | Address at which fetch restarts |

## Verification
A fetch lookup and a translation-unit write can fall on the same clock edge for the same address. The bench provokes this twice: once with an address that is not yet in the table, and once with an address already stored. It drives `fetch_valid` and `alloc_valid` together with identical addresses. In the following cycle both `stall` and `cfg_start` must be low. A plain lookup of the same address afterwards must hit. In the second case, the rotation must show that no row was spent on the rewrite.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } bbc_state_e;

endpackage

// File: rtl/bbc_tag_array.sv
module bbc_tag_array #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int CFG_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PC_W-1:0]    look_pc,
  input  logic               wr_en,
  input  logic [PC_W-1:0]    wr_pc,
  input  logic [CFG_W-1:0]   wr_cfg,
  input  logic [IDX_W-1:0]   victim_idx,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] look_hit_vec,
  output logic [CFG_W-1:0]   look_cfg,
  output logic               wr_hit
);

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] wr_match;
  logic [ENTRIES-1:0] wr_sel;
  logic [PC_W-1:0]    tag_q [ENTRIES];
  logic [CFG_W-1:0]   cfg_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    logic             valid_d;
    logic [PC_W-1:0]  tag_d;
    logic [CFG_W-1:0] cfg_d;

    assign look_hit_vec[g] = valid_q[g] && (tag_q[g] == look_pc);
    assign wr_match[g]     = valid_q[g] && (tag_q[g] == wr_pc);
    assign wr_sel[g]       = wr_en && (wr_hit ? wr_match[g]
                                              : (victim_idx == IDX_W'(g)));

    always_comb begin
      valid_d = valid_q[g];
      tag_d   = tag_q[g];
      cfg_d   = cfg_q[g];
      if (wr_sel[g]) begin
        valid_d = 1'b1;
        tag_d   = wr_pc;
        cfg_d   = wr_cfg;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (wr_sel[g]) begin
        valid_q[g] <= valid_d;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_sel[g]) begin
        tag_q[g] <= tag_d;
        cfg_q[g] <= cfg_d;
      end
    end
  end

  assign wr_hit    = |wr_match;
  assign valid_vec = valid_q;

  always_comb begin
    look_cfg = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_hit_vec[i]) begin
        look_cfg = look_cfg | cfg_q[i];
      end
    end
  end

endmodule

// File: rtl/bbc_victim.sv
module bbc_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               new_write,
  output logic [IDX_W-1:0]   victim_idx
);

  logic             full;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] rr_d;
  logic             rr_en;

  assign full = &valid_vec;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = full ? rr_q : free_idx;
  assign rr_en      = new_write && full;

  always_comb begin
    if (rr_q == IDX_W'(ENTRIES - 1)) begin
      rr_d = '0;
    end else begin
      rr_d = rr_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (rr_en) begin
      rr_q <= rr_d;
    end
  end

endmodule

// File: rtl/bbc_cfg_store.sv
module bbc_cfg_store #(
  parameter int CFG_W  = 4,
  parameter int PC_W   = 32,
  localparam int DEPTH = 1 << CFG_W
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_idx,
  input  logic [PC_W-1:0]  wr_data,
  input  logic [CFG_W-1:0] rd_idx,
  output logic [PC_W-1:0]  rd_data
);

  logic [PC_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/bbc_ctrl.sv
module bbc_ctrl
  import bbc_pkg::*;
#(
  parameter int CFG_W = 4,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic             look_hit,
  input  logic [CFG_W-1:0] look_cfg,
  input  logic             collide,
  input  logic             array_done,
  input  logic [PC_W-1:0]  ft_data,
  output logic             stall,
  output logic             cfg_start,
  output logic [CFG_W-1:0] cfg_index,
  output logic             resume_valid,
  output logic [PC_W-1:0]  resume_pc
);

  bbc_state_e       state_q, state_d;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             start_q, start_d;
  logic             rsm_q, rsm_d;
  logic [PC_W-1:0]  rpc_q, rpc_d;
  logic             cfg_en;
  logic             rpc_en;

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    start_d = 1'b0;
    rsm_d   = 1'b0;
    rpc_d   = rpc_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fetch_valid && look_hit && !collide) begin
          state_d = ST_RUN;
          cfg_d   = look_cfg;
          start_d = 1'b1;
        end
      end
      ST_RUN: begin
        if (array_done) begin
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        state_d = ST_IDLE;
        rsm_d   = 1'b1;
        rpc_d   = ft_data;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cfg_en = (state_q == ST_IDLE);
  assign rpc_en = (state_q == ST_DRAIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      rsm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      rsm_q   <= rsm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rpc_q <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (rpc_en) rpc_q <= rpc_d;
    end
  end

  assign stall        = (state_q != ST_IDLE);
  assign cfg_start    = start_q;
  assign cfg_index    = cfg_q;
  assign resume_valid = rsm_q;
  assign resume_pc    = rpc_q;

endmodule

// File: rtl/bb_lookup_cache.sv
module bb_lookup_cache #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int CFG_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             alloc_valid,
  input  logic [PC_W-1:0]  alloc_pc,
  input  logic [CFG_W-1:0] alloc_cfg,
  input  logic [PC_W-1:0]  alloc_fallthru,
  input  logic             array_done,
  output logic             stall,
  output logic             cfg_start,
  output logic [CFG_W-1:0] cfg_index,
  output logic             resume_valid,
  output logic [PC_W-1:0]  resume_pc
);

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] look_hit_vec;
  logic [CFG_W-1:0]   look_cfg;
  logic               wr_hit;
  logic [IDX_W-1:0]   victim_idx;
  logic               collide;
  logic [PC_W-1:0]    ft_data;
  logic               new_write;

  assign collide   = alloc_valid && (alloc_pc == fetch_pc);
  assign new_write = alloc_valid && !wr_hit;

  bbc_tag_array #(.ENTRIES(ENTRIES), .PC_W(PC_W), .CFG_W(CFG_W)) u_tags (
    .clk          (clk),
    .rst_n        (rst_n),
    .look_pc      (fetch_pc),
    .wr_en        (alloc_valid),
    .wr_pc        (alloc_pc),
    .wr_cfg       (alloc_cfg),
    .victim_idx   (victim_idx),
    .valid_vec    (valid_vec),
    .look_hit_vec (look_hit_vec),
    .look_cfg     (look_cfg),
    .wr_hit       (wr_hit)
  );

  bbc_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_vec  (valid_vec),
    .new_write  (new_write),
    .victim_idx (victim_idx)
  );

  bbc_cfg_store #(.CFG_W(CFG_W), .PC_W(PC_W)) u_store (
    .clk     (clk),
    .wr_en   (alloc_valid),
    .wr_idx  (alloc_cfg),
    .wr_data (alloc_fallthru),
    .rd_idx  (cfg_index),
    .rd_data (ft_data)
  );

  bbc_ctrl #(.CFG_W(CFG_W), .PC_W(PC_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_valid  (fetch_valid),
    .look_hit     (|look_hit_vec),
    .look_cfg     (look_cfg),
    .collide      (collide),
    .array_done   (array_done),
    .ft_data      (ft_data),
    .stall        (stall),
    .cfg_start    (cfg_start),
    .cfg_index    (cfg_index),
    .resume_valid (resume_valid),
    .resume_pc    (resume_pc)
  );

endmodule

// File: rtl/bbc_checker.sv
module bbc_checker #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_valid,
  input logic [PC_W-1:0]    fetch_pc,
  input logic               alloc_valid,
  input logic [PC_W-1:0]    alloc_pc,
  input logic               stall,
  input logic               cfg_start,
  input logic               resume_valid,
  input logic [ENTRIES-1:0] hit_vec
);

  // R2: a start pulse always comes with the stall, and lasts one cycle
  assert_start_stalls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |-> stall);
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_start |=> !cfg_start);

  // R3: a miss while idle does not stall
  assert_miss_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && fetch_valid && !(|hit_vec)) |=> !stall);

  // R4: no second start while the stall continues
  assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |-> !cfg_start);

  // R5: stall release coincides with the resume pulse
  assert_release_resume_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> resume_valid);
  assert_resume_unstalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |-> !stall);

  // R7: an address occupies at most one row
  assert_single_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R9: same-cycle lookup and write of one address never starts the array
  assert_collide_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && fetch_valid && alloc_valid && (fetch_pc == alloc_pc)) |=> !cfg_start);

endmodule

bind bb_lookup_cache bbc_checker #(.ENTRIES(ENTRIES), .PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_valid  (fetch_valid),
  .fetch_pc     (fetch_pc),
  .alloc_valid  (alloc_valid),
  .alloc_pc     (alloc_pc),
  .stall        (stall),
  .cfg_start    (cfg_start),
  .resume_valid (resume_valid),
  .hit_vec      (look_hit_vec)
);

// File: tb/tb_bb_lookup_cache.sv
module tb_bb_lookup_cache;

  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_pc;
  logic        alloc_valid;
  logic [31:0] alloc_pc;
  logic [3:0]  alloc_cfg;
  logic [31:0] alloc_fallthru;
  logic        array_done;
  logic        stall;
  logic        cfg_start;
  logic [3:0]  cfg_index;
  logic        resume_valid;
  logic [31:0] resume_pc;

  int checks;
  int fails;
  int cyc;
  bit finished;
  logic [31:0] ft_model [16];

  bb_lookup_cache dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid    (fetch_valid),
    .fetch_pc       (fetch_pc),
    .alloc_valid    (alloc_valid),
    .alloc_pc       (alloc_pc),
    .alloc_cfg      (alloc_cfg),
    .alloc_fallthru (alloc_fallthru),
    .array_done     (array_done),
    .stall          (stall),
    .cfg_start      (cfg_start),
    .cfg_index      (cfg_index),
    .resume_valid   (resume_valid),
    .resume_pc      (resume_pc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] pc_of(input int i);
    return 32'h0000_1000 + 32'(i) * 32'h10;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [31:0] pc, input logic [3:0] cfg,
                          input logic [31:0] ft);
    alloc_valid    = 1'b1;
    alloc_pc       = pc;
    alloc_cfg      = cfg;
    alloc_fallthru = ft;
    @(negedge clk);
    alloc_valid    = 1'b0;
    ft_model[cfg]  = ft;
  endtask

  task automatic expect_miss(input logic [31:0] pc, input string req);
    fetch_valid = 1'b1;
    fetch_pc    = pc;
    @(negedge clk);
    chk(!stall && !cfg_start, req, {30'd0, stall, cfg_start}, 32'd0);
    fetch_valid = 1'b0;
  endtask

  task automatic run_block(input logic [31:0] pc, input logic [3:0] exp_cfg,
                           input string req);
    logic [31:0] exp_ft;
    exp_ft      = ft_model[exp_cfg];
    fetch_valid = 1'b1;
    fetch_pc    = pc;
    @(negedge clk);
    chk(stall && cfg_start && (cfg_index == exp_cfg), {req, " R2 hit"},
        {stall, cfg_start, 26'd0, cfg_index}, {2'b11, 26'd0, exp_cfg});
    @(negedge clk);
    chk(stall && !cfg_start, "R4 lookup ignored while stalled",
        {30'd0, stall, cfg_start}, 32'd2);
    fetch_valid = 1'b0;
    array_done  = 1'b1;
    @(negedge clk);
    chk(stall && !resume_valid, "R5 stall held one cycle after done",
        {30'd0, stall, resume_valid}, 32'd2);
    array_done = 1'b0;
    @(negedge clk);
    chk(!stall && resume_valid && (resume_pc == exp_ft),
        {req, " R5 resume address"}, resume_pc, exp_ft);
  endtask

  task automatic t_reset;
    chk(!stall && !cfg_start && !resume_valid, "R1 outputs after reset",
        {29'd0, stall, cfg_start, resume_valid}, 32'd0);
    expect_miss(pc_of(0), "R1 empty table misses");
  endtask

  task automatic t_fill;
    for (int i = 0; i < 16; i++) begin
      do_alloc(pc_of(i), 4'(i) ^ 4'h5, 32'h0000_8000 + 32'(i));
    end
    run_block(pc_of(0), 4'h5, "R6 first row");
    run_block(pc_of(3), 4'h6, "R6 fourth row");
    run_block(pc_of(15), 4'hA, "R6 last row");
  endtask

  task automatic t_miss;
    expect_miss(32'h0000_9990, "R3 unknown address");
    expect_miss(pc_of(3) + 32'd4, "R3 near address");
  endtask

  task automatic t_update;
    do_alloc(pc_of(3), 4'hA, 32'hAAAA_0000);
    run_block(pc_of(3), 4'hA, "R7 rewritten slot");
    run_block(pc_of(15), 4'hA, "R10 latest slot write");
  endtask

  task automatic t_rotate;
    do_alloc(32'h0000_2000, 4'h1, 32'h0000_9001);
    expect_miss(pc_of(0), "R8 row 0 evicted first");
    run_block(32'h0000_2000, 4'h1, "R8 replacement");
    run_block(pc_of(1), 4'h4, "R8 row 1 kept");
    do_alloc(32'h0000_2100, 4'h2, 32'h0000_9002);
    expect_miss(pc_of(1), "R8 row 1 evicted second");
    run_block(pc_of(2), 4'h7, "R8 row 2 kept");
  endtask

  task automatic t_collide;
    fetch_valid    = 1'b1;
    fetch_pc       = 32'h0000_3000;
    alloc_valid    = 1'b1;
    alloc_pc       = 32'h0000_3000;
    alloc_cfg      = 4'h3;
    alloc_fallthru = 32'h0000_9003;
    @(negedge clk);
    chk(!stall && !cfg_start, "R9 new address collision misses",
        {30'd0, stall, cfg_start}, 32'd0);
    fetch_valid = 1'b0;
    alloc_valid = 1'b0;
    ft_model[3] = 32'h0000_9003;
    run_block(32'h0000_3000, 4'h3, "R9 later lookup");
    fetch_valid    = 1'b1;
    fetch_pc       = pc_of(4);
    alloc_valid    = 1'b1;
    alloc_pc       = pc_of(4);
    alloc_cfg      = 4'h1;
    alloc_fallthru = 32'h0000_9001;
    @(negedge clk);
    chk(!stall && !cfg_start, "R9 present address collision misses",
        {30'd0, stall, cfg_start}, 32'd0);
    fetch_valid = 1'b0;
    alloc_valid = 1'b0;
    run_block(pc_of(4), 4'h1, "R9 rewritten row hits");
    do_alloc(32'h0000_4000, 4'h0, 32'h0000_9000);
    expect_miss(pc_of(3), "R7 rewrite spent no row");
    run_block(pc_of(5), 4'h0, "R7 row 5 kept");
  endtask

  initial begin
    checks = 0;
    fails = 0;
    cyc = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    fetch_valid = 1'b0;
    fetch_pc = '0;
    alloc_valid = 1'b0;
    alloc_pc = '0;
    alloc_cfg = '0;
    alloc_fallthru = '0;
    array_done = 1'b0;
    for (int i = 0; i < 16; i++) ft_model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_miss();
    t_update();
    t_rotate();
    t_collide();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule